// File: doc/BRIEF.md
# Independent Watchdog Timer

This block is a watchdog that runs in its own slow clock domain, separate from the system clock. System-side logic sets a 12-bit reload value and a 3-bit prescaler code, then issues a start request. From then on the block counts down once every 4·2^PR slow-clock cycles. If the count passes zero before a refresh arrives, it raises a reset request for a fixed number of slow cycles. It then reloads and keeps counting.

Start and refresh are single-cycle pulses in the system domain. Each one flips a toggle flop, and the toggle is carried into the slow domain through a two-flop synchronizer. The reload value and the prescaler code are quasi-static buses. The slow domain reads them only when it reloads, which happens on start, on refresh and on expiry. Once started, the watchdog cannot be stopped except by a reset. A sticky system-side output keeps the slow oscillator requested from the first start request onward.

Top module: `indep_wdog`

## Requirements
- R1: After reset, `rst_req`, `wdg_run` and `slow_clk_keep` are 0, and `wdg_count` equals `reload_val`.
- R2: While not started, `wdg_count` follows `reload_val` on every slow edge and `rst_req` stays 0.
- R3: While running, `wdg_count` drops by one every 4·2^P slow cycles. P is the prescaler code latched at the last reload, and codes 7 and above act as 6, so the longest divider is 256.
- R4: On the divider tick where `wdg_count` is 0 and no refresh is arriving, `rst_req` rises and `wdg_count` reloads. Measured from the start event, the expiry comes (reload+1)·divider slow cycles later.
- R5: A refresh at any time while running reloads the count and restarts the divider, so no reset request is issued. A refresh before start has no effect.
- R6: Each `rst_req` pulse lasts exactly 4 slow cycles.
- R7: Once `wdg_run` is 1, it stays 1 until reset. A further start request has no effect on the count.
- R8: `slow_clk_keep` goes to 1 on the system edge that takes a start request, and it stays 1 until `rst_sys`.
- R9: A request registered at a system edge acts on the slow-domain state at the third rising slow edge after that system edge.
- R10: The prescaler code and the reload value are sampled only at a reload. Changing them in the middle of a countdown leaves that countdown's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| start_req | input | 1 | One-cycle start pulse |
| refresh_req | input | 1 | One-cycle refresh pulse |
| pr_code | input | 3 | Prescaler code, divider 4·2^code, clamped at 6 |
| reload_val | input | 12 | Countdown reload value |
| clk_slow | input | 1 | Low-speed watchdog clock |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| slow_clk_keep | output | 1 | Sticky request to keep the slow oscillator on |
| wdg_run | output | 1 | Watchdog started (slow domain) |
| wdg_count | output | 12 | Current countdown value (slow domain) |
| rst_req | output | 1 | Reset request pulse (slow domain) |

## Verification
The assertions assume that start and refresh pulses are spaced more than three slow cycles apart, so each toggle edge reaches the slow domain as one event. They also assume that `reload_val` and `pr_code` are stable around the slow edges where a reload happens. The stimulus meets both assumptions. Every request is issued just after a falling slow edge, and no second request follows within a dozen slow cycles. The buses are changed only in the middle of a countdown, well away from any reload.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int WDG_CNT_W   = 12;
    localparam int PR_W        = 3;
    localparam int PR_MAX      = 6;
    localparam int PULSE_LEN   = 4;
    localparam int SYNC_STAGES = 2;
    localparam int PRE_W       = PR_MAX + 2;
    localparam int PULSE_W     = $clog2(PULSE_LEN + 1);

    typedef logic [WDG_CNT_W-1:0] wdg_cnt_t;
    typedef logic [PR_W-1:0]      wdg_pr_t;
    typedef logic [PRE_W-1:0]     wdg_pre_t;

    typedef enum logic {
        WD_IDLE = 1'b0,
        WD_RUN  = 1'b1
    } wdg_mode_e;

    typedef struct packed {
        logic refresh;
        logic start;
    } wdg_evt_t;

    function automatic wdg_pr_t clamp_pr(input wdg_pr_t code);
        return (int'(code) > PR_MAX) ? wdg_pr_t'(PR_MAX) : code;
    endfunction

    function automatic wdg_pre_t last_pre(input wdg_pr_t code);
        logic [PRE_W:0] span;
        span = (PRE_W+1)'(4) << clamp_pr(code);
        span = span - 1'b1;
        return span[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/wdg_req_sync.sv
module wdg_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_src,
    input  logic req,
    input  logic clk_dst,
    input  logic rst_dst,
    output logic evt
);
    logic              tgl;
    logic [STAGES:0]   shift_q;

    always_ff @(posedge clk_src) begin
        if (rst_src)  tgl <= 1'b0;
        else if (req) tgl <= ~tgl;
    end

    always_ff @(posedge clk_dst) begin
        if (rst_dst) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-1:0], tgl};
    end

    assign evt = shift_q[STAGES] ^ shift_q[STAGES-1];

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    clear,
    input  wdg_pr_t pr,
    output logic    tick
);
    wdg_pre_t pre_q;

    always_comb tick = run && (pre_q == last_pre(pr));

    always_ff @(posedge clk) begin
        if (rst || !run || clear) pre_q <= '0;
        else if (tick)            pre_q <= '0;
        else                      pre_q <= pre_q + 1'b1;
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wdg_evt_t evt,
    input  wdg_cnt_t reload_val,
    input  wdg_pr_t  pr_code,
    input  logic     tick,
    output logic     run,
    output logic     clear,
    output wdg_pr_t  eff_pr,
    output wdg_cnt_t count,
    output logic     rst_req
);
    wdg_mode_e            mode_q;
    wdg_cnt_t             cnt_q;
    wdg_pr_t              pr_q;
    logic [PULSE_W-1:0]   pulse_q;
    logic                 start_ok, refresh_ok, expire, load;

    always_comb begin
        start_ok   = evt.start   && (mode_q == WD_IDLE);
        refresh_ok = evt.refresh && (mode_q == WD_RUN);
        expire     = tick && (cnt_q == '0) && !refresh_ok;
        load       = start_ok || refresh_ok || expire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= WD_IDLE;
            cnt_q   <= reload_val;
            pr_q    <= '0;
            pulse_q <= '0;
        end else begin
            if (start_ok) mode_q <= WD_RUN;
            if (mode_q == WD_IDLE || load) cnt_q <= reload_val;
            else if (tick)                 cnt_q <= cnt_q - 1'b1;
            if (load) pr_q <= clamp_pr(pr_code);
            if (expire)             pulse_q <= PULSE_W'(PULSE_LEN);
            else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
        end
    end

    assign run     = (mode_q == WD_RUN);
    assign clear   = start_ok || refresh_ok;
    assign eff_pr  = pr_q;
    assign count   = cnt_q;
    assign rst_req = (pulse_q != '0);

    // R7
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> run);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !rst_req);
    // R3
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !evt.refresh) |=> $stable(count));
    // R4
    expire_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count == '0 && !evt.refresh) |=> (rst_req && count == $past(reload_val)));
    // R6
    pulse_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |=> rst_req);

endmodule

// File: rtl/indep_wdog.sv
module indep_wdog
    import wdg_pkg::*;
(
    input  logic        clk_sys,
    input  logic        rst_sys,
    input  logic        start_req,
    input  logic        refresh_req,
    input  logic [2:0]  pr_code,
    input  logic [11:0] reload_val,
    input  logic        clk_slow,
    input  logic        rst_slow,
    output logic        slow_clk_keep,
    output logic        wdg_run,
    output logic [11:0] wdg_count,
    output logic        rst_req
);
    localparam int N_REQ = 2;

    logic [N_REQ-1:0] req_v, evt_v;
    wdg_evt_t         evt;
    logic             tick, clear;
    wdg_pr_t          eff_pr;

    assign req_v = {refresh_req, start_req};

    for (genvar i = 0; i < N_REQ; i++) begin : g_sync
        wdg_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_src (clk_sys),
            .rst_src (rst_sys),
            .req     (req_v[i]),
            .clk_dst (clk_slow),
            .rst_dst (rst_slow),
            .evt     (evt_v[i])
        );
    end

    assign evt = '{refresh: evt_v[1], start: evt_v[0]};

    always_ff @(posedge clk_sys) begin
        if (rst_sys)        slow_clk_keep <= 1'b0;
        else if (start_req) slow_clk_keep <= 1'b1;
    end

    wdg_prescaler u_pre (
        .clk   (clk_slow),
        .rst   (rst_slow),
        .run   (wdg_run),
        .clear (clear),
        .pr    (eff_pr),
        .tick  (tick)
    );

    wdg_core u_core (
        .clk        (clk_slow),
        .rst        (rst_slow),
        .evt        (evt),
        .reload_val (reload_val),
        .pr_code    (pr_code),
        .tick       (tick),
        .run        (wdg_run),
        .clear      (clear),
        .eff_pr     (eff_pr),
        .count      (wdg_count),
        .rst_req    (rst_req)
    );

    // R8
    keep_sticky_chk: assert property (@(posedge clk_sys) disable iff (rst_sys)
        slow_clk_keep |=> slow_clk_keep);

endmodule

// File: tb/indep_wdog_test.sv
module indep_wdog_test;
    logic        clk_sys = 0, clk_slow = 0;
    logic        rst_sys = 1, rst_slow = 1;
    logic        start_req = 0, refresh_req = 0;
    logic [2:0]  pr_code = 0;
    logic [11:0] reload_val = 12'd10;
    logic        slow_clk_keep, wdg_run, rst_req;
    logic [11:0] wdg_count;

    int checks = 0, errors = 0;
    int m_run, m_cnt, m_pr, m_pre, m_pulse;
    int st_cd = 0, rf_cd = 0, st_seq = 0, rf_seq = 0, st_seen = 0, rf_seen = 0;
    bit model_live = 0;

    indep_wdog uut (
        .clk_sys(clk_sys), .rst_sys(rst_sys), .start_req(start_req),
        .refresh_req(refresh_req), .pr_code(pr_code), .reload_val(reload_val),
        .clk_slow(clk_slow), .rst_slow(rst_slow), .slow_clk_keep(slow_clk_keep),
        .wdg_run(wdg_run), .wdg_count(wdg_count), .rst_req(rst_req)
    );

    always #4 clk_sys = ~clk_sys;
    initial begin
        #2;
        forever begin clk_slow = 1; #32; clk_slow = 0; #32; end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampm(input int c);
        return (c > 6) ? 6 : c;
    endfunction

    // behavioural reference model, slow domain
    always @(posedge clk_slow) begin
        bit st_now, rf_now, expire;
        if (rst_slow) begin
            m_run = 0; m_cnt = reload_val; m_pr = 0; m_pre = 0; m_pulse = 0;
            st_cd = 0; rf_cd = 0; st_seen = st_seq; rf_seen = rf_seq;
            model_live = 1;
        end else begin
            if (st_seq != st_seen) begin st_seen = st_seq; st_cd = 3; end
            if (rf_seq != rf_seen) begin rf_seen = rf_seq; rf_cd = 3; end
            st_now = (st_cd == 1);
            rf_now = (rf_cd == 1);
            if (st_cd > 0) st_cd--;
            if (rf_cd > 0) rf_cd--;
            expire = 0;
            if (!m_run) begin
                if (st_now) begin m_run = 1; m_pr = clampm(pr_code); m_pre = 0; end
                m_cnt = reload_val;
            end else if (rf_now) begin
                m_cnt = reload_val; m_pr = clampm(pr_code); m_pre = 0;
            end else if (m_pre == (4 << m_pr) - 1) begin
                m_pre = 0;
                if (m_cnt == 0) begin
                    expire = 1; m_cnt = reload_val; m_pr = clampm(pr_code);
                end else m_cnt--;
            end else m_pre++;
            if (expire) m_pulse = 4;
            else if (m_pulse > 0) m_pulse--;
        end
    end

    always @(negedge clk_slow) begin
        if (model_live && !rst_slow) begin
            chk(int'(wdg_count) == m_cnt, "R3 count vs model", int'(wdg_count), m_cnt);
            chk(int'(wdg_run) == m_run, "R7 run vs model", int'(wdg_run), m_run);
            chk(int'(rst_req) == int'(m_pulse > 0), "R6 rst_req vs model", int'(rst_req), int'(m_pulse > 0));
        end
    end

    task automatic send(input bit is_start);
        @(negedge clk_slow);
        @(negedge clk_sys);
        if (is_start) begin start_req = 1; st_seq++; end
        else begin refresh_req = 1; rf_seq++; end
        @(negedge clk_sys);
        start_req = 0; refresh_req = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk_sys);
        checks++; errors++;
        $display("FAIL R4 watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int k, w, hits, t;
        bit prev;
        repeat (4) @(negedge clk_slow);
        @(negedge clk_sys);
        rst_sys = 0; rst_slow = 0;
        @(negedge clk_slow);
        chk(rst_req == 0, "R1 rst_req after reset", int'(rst_req), 0);
        chk(wdg_run == 0, "R1 run after reset", int'(wdg_run), 0);
        chk(slow_clk_keep == 0, "R1 keep after reset", int'(slow_clk_keep), 0);
        chk(wdg_count == 10, "R1 count after reset", int'(wdg_count), 10);

        // R2: idle count follows reload
        reload_val = 12'd7;
        repeat (2) @(negedge clk_slow);
        chk(wdg_count == 7, "R2 idle count follows reload", int'(wdg_count), 7);
        // R5: refresh before start is ignored
        send(0);
        repeat (6) @(negedge clk_slow);
        chk(wdg_run == 0, "R5 refresh before start ignored", int'(wdg_run), 0);
        chk(wdg_count == 7, "R5 count after early refresh", int'(wdg_count), 7);

        // start with reload 5, divider 4
        reload_val = 12'd5; pr_code = 3'd0;
        send(1);
        chk(slow_clk_keep == 1, "R8 keep after start", int'(slow_clk_keep), 1);
        k = 0;
        while (!rst_req && k < 100) begin
            @(negedge clk_slow); k++;
            if (k == 2) chk(wdg_run == 0, "R9 not yet running at 2", int'(wdg_run), 0);
            if (k == 3) chk(wdg_run == 1, "R9 running at 3", int'(wdg_run), 1);
        end
        chk(k == 27, "R4 expiry delay", k, 27);
        w = 1;
        forever begin
            @(negedge clk_slow);
            if (rst_req) w++; else break;
        end
        chk(w == 4, "R6 pulse width", w, 4);

        // R5: periodic refresh prevents reset
        hits = 0;
        repeat (10) begin
            send(0);
            repeat (12) @(negedge clk_slow) if (rst_req) hits++;
        end
        chk(hits == 0, "R5 refresh keeps off reset", hits, 0);

        // R10: change settings mid countdown
        pr_code = 3'd7; reload_val = 12'd2;
        k = 0;
        while (!rst_req && k < 200) begin @(negedge clk_slow); k++; end
        chk(k > 0 && k <= 30, "R10 old timing kept", k, 30);
        // R3: clamped divider 256, reload 2 -> 768 cycles
        t = 0; prev = 1;
        while (t < 2000) begin
            @(negedge clk_slow); t++;
            if (rst_req && !prev) break;
            prev = rst_req;
        end
        chk(t == 768, "R3 clamped divider period", t, 768);

        // R7: second start has no effect
        send(1);
        repeat (10) @(negedge clk_slow);
        chk(wdg_run == 1, "R7 still running", int'(wdg_run), 1);
        chk(slow_clk_keep == 1, "R8 keep holds", int'(slow_clk_keep), 1);

        // R7: only reset stops it
        @(negedge clk_slow);
        rst_sys = 1; rst_slow = 1;
        repeat (3) @(negedge clk_slow);
        @(negedge clk_sys);
        rst_sys = 0; rst_slow = 0;
        @(negedge clk_slow);
        chk(wdg_run == 0, "R7 reset stops watchdog", int'(wdg_run), 0);
        chk(slow_clk_keep == 0, "R8 reset clears keep", int'(slow_clk_keep), 0);
        chk(wdg_count == 2, "R1 count after second reset", int'(wdg_count), 2);
        finish_run();
    end
endmodule